// File: doc/BRIEF.md
# Translation Table Base Selector

This block sits at the front of a stage-one page-table walker. Each request carries a virtual address, a translation control word, both table base registers and a flag for the 64-bit or 32-bit address regime. The block decides which half of the address space the address belongs to. The low half uses base 0 and the high half uses base 1. If the address is in neither half, it reports a translation fault.

For a selected region, the block also works out the walk's starting level from the region's effective address width. It then produces the aligned physical address of the first table to fetch. In the 64-bit regime the size fields are forced into a legal window. The top byte of the address can optionally be treated as a tag, and address bit 55 chooses which tag enable applies. The result is registered and appears with a valid strobe one cycle after the request.

Top module: `xlat_base_select`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Response fields update only on an accepted request and hold otherwise. Reset clears `rsp_valid`, `rsp_fault`, `rsp_sel`, `rsp_level` and `rsp_base`.
- R2: The low-region size is taken from control bits [5:0] and the high-region size from bits [21:16]. In the 64-bit regime each size is clamped to 16..39, so a value of 0 acts as 16 and a value of 63 acts as 39.
- R3: With W the regime width, the low region (`rsp_sel`=0) matches when its size S is nonzero and address bits [W-1:W-S] are all zero. The low region is tested before the high region.
- R4: The high region (`rsp_sel`=1) matches when its size S is nonzero and address bits [W-1:W-S] are all one.
- R5: If neither region matches and both sizes are nonzero, `rsp_fault` is 1, and `rsp_sel`, `rsp_level` and `rsp_base` are all 0.
- R6: In the 32-bit regime (`req_wide`=0), W is 32 and each size uses only the low 3 bits of its field. Address bits [63:32] and the tag enables have no effect. If no region matches, a zero-size low region takes the address, else a zero-size high region takes it.
- R7: In the 64-bit regime, address bit 55 picks the tag enable: control bit 38 when bit 55 is 1, and control bit 37 when it is 0. When the picked enable is 1, address bits [63:56] are left out of the region match.
- R8: With effective width E = W − S of the selected region, `rsp_level` is 0 for E in 40..48, 1 for E in 31..39 and 2 for E in 25..30.
- R9: `rsp_base` is bits [47:0] of the selected base register, with every bit below position E − 9·(4 − `rsp_level`) cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_wide | input | 1 | 1: 64-bit regime, 0: 32-bit regime |
| req_vaddr | input | 64 | Virtual address |
| req_ctrl | input | 64 | Translation control word |
| req_base0 | input | 64 | Low-region table base register |
| req_base1 | input | 64 | High-region table base register |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Address is in no region |
| rsp_sel | output | 1 | Selected base register |
| rsp_level | output | 2 | Starting lookup level |
| rsp_base | output | 48 | Aligned first table address |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle strobe timing and the holding of the response between requests;
- a faulting response carrying all-zero fields;
- every non-faulting base having at least its four lowest bits clear;
- a 32-bit request never yielding level 0 or 3.

Other behaviour only the bench scenarios can show, by comparison with an independent model:
- which region wins for a given address;
- the effect of clamping;
- the per-region tag enable picked by bit 55;
- the exact alignment position.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
    localparam int VA_W        = 64;
    localparam int NARROW_W    = 32;
    localparam int PA_W        = 48;
    localparam int CTRL_W      = 64;
    localparam int SZ_W        = 6;
    localparam int NSZ_W       = 3;
    localparam int SZ_MIN      = 16;
    localparam int SZ_MAX      = 39;
    localparam int STRIDE      = 9;
    localparam int LEVELS      = 4;
    localparam int PAGE_BITS   = 12;
    localparam int TAG_W       = 8;
    localparam int TAG_SEL_BIT = 55;
    localparam int TBI_LO_BIT  = 37;
    localparam int TBI_HI_BIT  = 38;
    localparam int SZ0_LSB     = 0;
    localparam int SZ1_LSB     = 16;
    localparam int NREG        = 2;
    localparam int IDX_W       = $clog2(VA_W) + 1;
    localparam int LVL_W       = $clog2(LEVELS);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [SZ_W-1:0]  size_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [PA_W-1:0]  pa_t;

    typedef enum logic [1:0] {
        PICK_LOW   = 2'd0,
        PICK_HIGH  = 2'd1,
        PICK_FAULT = 2'd2
    } pick_e;

    typedef struct packed {
        logic fault;
        logic sel;
        lvl_t level;
        pa_t  base;
    } xbs_rsp_t;

    // Legalise a raw size field for the active regime.
    function automatic size_t norm_size(input size_t raw, input logic wide);
        if (wide) begin
            if (raw < size_t'(SZ_MIN)) return size_t'(SZ_MIN);
            if (raw > size_t'(SZ_MAX)) return size_t'(SZ_MAX);
            return raw;
        end
        return size_t'(raw[NSZ_W-1:0]);
    endfunction

    // Level at which a walk covering ew address bits begins.
    function automatic lvl_t first_level(input idx_t ew);
        lvl_t l;
        l = lvl_t'(LEVELS - 1);
        for (int k = 1; k < LEVELS; k++)
            if (int'(ew) > PAGE_BITS + k * STRIDE) l = lvl_t'(LEVELS - 1 - k);
        return l;
    endfunction

    // Lowest base bit that survives alignment of the first table.
    function automatic idx_t align_shift(input idx_t ew, input lvl_t lv);
        return idx_t'(int'(ew) - STRIDE * (LEVELS - int'(lv)));
    endfunction
endpackage

// File: rtl/xbs_size_norm.sv
module xbs_size_norm
    import xbs_pkg::*;
(
    input  size_t raw,
    input  logic  wide,
    output size_t sz
);
    assign sz = norm_size(raw, wide);
endmodule

// File: rtl/xbs_region_check.sv
module xbs_region_check
    import xbs_pkg::*;
#(
    parameter bit MATCH_ONES = 1'b0
) (
    input  logic [VA_W-1:0] vaddr,
    input  size_t           sz,
    input  idx_t            width,
    input  logic            tag_en,
    output logic            hit
);
    idx_t lo;
    idx_t hi;

    always_comb begin
        lo  = width - idx_t'(sz);
        hi  = tag_en ? (width - idx_t'(TAG_W)) : width;
        hit = (sz != '0);
        for (int i = 0; i < VA_W; i++) begin
            if (i >= int'(lo) && i < int'(hi) && vaddr[i] != MATCH_ONES)
                hit = 1'b0;
        end
    end
endmodule

// File: rtl/xbs_base_mask.sv
module xbs_base_mask
    import xbs_pkg::*;
(
    input  pa_t  raw,
    input  idx_t ew,
    output lvl_t level,
    output pa_t  base
);
    idx_t sh;

    always_comb begin
        level = first_level(ew);
        sh    = align_shift(ew, level);
        base  = raw & ~((pa_t'(1) << sh) - pa_t'(1));
    end
endmodule

// File: rtl/xlat_base_select.sv
module xlat_base_select
    import xbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wide,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [CTRL_W-1:0] req_ctrl,
    input  logic [VA_W-1:0]   req_base0,
    input  logic [VA_W-1:0]   req_base1,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_sel,
    output logic [LVL_W-1:0]  rsp_level,
    output logic [PA_W-1:0]   rsp_base
);
    idx_t            width;
    logic            tag_en;
    size_t           raw_sz [NREG];
    size_t           sz     [NREG];
    logic [NREG-1:0] hit;
    pick_e           pick;
    logic            sel_hi;
    idx_t            ew;
    pa_t             raw_base;
    lvl_t            lvl;
    pa_t             masked;
    xbs_rsp_t        nxt;
    xbs_rsp_t        cur;
    logic            unused_bits;

    assign width  = req_wide ? idx_t'(VA_W) : idx_t'(NARROW_W);
    assign tag_en = req_wide & (req_vaddr[TAG_SEL_BIT] ? req_ctrl[TBI_HI_BIT]
                                                       : req_ctrl[TBI_LO_BIT]);

    for (genvar r = 0; r < NREG; r++) begin : g_region
        localparam int FIELD_LSB = (r == 0) ? SZ0_LSB : SZ1_LSB;
        assign raw_sz[r] = req_ctrl[FIELD_LSB +: SZ_W];

        xbs_size_norm i_norm (
            .raw  (raw_sz[r]),
            .wide (req_wide),
            .sz   (sz[r])
        );

        xbs_region_check #(.MATCH_ONES(r == 1)) i_check (
            .vaddr  (req_vaddr),
            .sz     (sz[r]),
            .width  (width),
            .tag_en (tag_en),
            .hit    (hit[r])
        );
    end

    // Matches win over fallbacks; low region before high in each tier.
    always_comb begin
        if (hit[0])              pick = PICK_LOW;
        else if (hit[1])         pick = PICK_HIGH;
        else if (sz[0] == '0)    pick = PICK_LOW;
        else if (sz[1] == '0)    pick = PICK_HIGH;
        else                     pick = PICK_FAULT;
    end

    assign sel_hi   = (pick == PICK_HIGH);
    assign ew       = width - idx_t'(sel_hi ? sz[1] : sz[0]);
    assign raw_base = sel_hi ? req_base1[PA_W-1:0] : req_base0[PA_W-1:0];

    xbs_base_mask i_mask (
        .raw   (raw_base),
        .ew    (ew),
        .level (lvl),
        .base  (masked)
    );

    always_comb begin
        nxt = '0;
        if (pick == PICK_FAULT) begin
            nxt.fault = 1'b1;
        end else begin
            nxt.sel   = sel_hi;
            nxt.level = lvl;
            nxt.base  = masked;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            cur       <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign rsp_fault = cur.fault;
    assign rsp_sel   = cur.sel;
    assign rsp_level = cur.level;
    assign rsp_base  = cur.base;

    assign unused_bits = ^{req_base0[VA_W-1:PA_W], req_base1[VA_W-1:PA_W],
                           req_ctrl[CTRL_W-1:TBI_HI_BIT+1],
                           req_ctrl[TBI_LO_BIT-1:SZ1_LSB+SZ_W],
                           req_ctrl[SZ1_LSB-1:SZ0_LSB+SZ_W]};
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker
    import xbs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_wide,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic             rsp_sel,
    input logic [LVL_W-1:0] rsp_level,
    input logic [PA_W-1:0]  rsp_base
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_hold_fields_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_base) && $stable(rsp_fault)
                       && $stable(rsp_level) && $stable(rsp_sel));

    assert_fault_clean_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_base == '0 && rsp_level == '0 && !rsp_sel);

    assert_base_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_base[3:0] == 4'h0);

    assert_narrow_level_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_wide |=> rsp_fault || rsp_level == 2'd1 || rsp_level == 2'd2);
endmodule

bind xlat_base_select xbs_checker i_xbs_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_wide  (req_wide),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_sel   (rsp_sel),
    .rsp_level (rsp_level),
    .rsp_base  (rsp_base)
);

// File: tb/test_xlat_base_select.sv
module test_xlat_base_select;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_wide = 1'b1;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_ctrl = '0;
    logic [63:0] req_base0 = '0;
    logic [63:0] req_base1 = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic        rsp_sel;
    logic [1:0]  rsp_level;
    logic [47:0] rsp_base;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xlat_base_select i_xlat_base_select (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide),
        .req_vaddr(req_vaddr), .req_ctrl(req_ctrl), .req_base0(req_base0),
        .req_base1(req_base1), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_sel(rsp_sel), .rsp_level(rsp_level), .rsp_base(rsp_base)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ctrl(input int s0, input int s1, input bit t0, input bit t1);
        logic [63:0] c;
        c = '0;
        c[5:0]   = s0[5:0];
        c[21:16] = s1[5:0];
        c[37]    = t0;
        c[38]    = t1;
        return c;
    endfunction

    // Independent reference built from the requirement text.
    task automatic ref_model(input bit wide, input logic [63:0] va, input logic [63:0] ctrl,
                             input logic [63:0] b0, input logic [63:0] b1,
                             output bit f, output bit s, output int lv, output logic [47:0] bs);
        int w, s0, s1, top, ew, sh;
        bit tb, m0, m1;
        logic [47:0] raw;
        w  = wide ? 64 : 32;
        s0 = wide ? int'(ctrl[5:0])   : int'(ctrl[2:0]);
        s1 = wide ? int'(ctrl[21:16]) : int'(ctrl[18:16]);
        if (wide) begin
            if (s0 < 16) s0 = 16;
            if (s0 > 39) s0 = 39;
            if (s1 < 16) s1 = 16;
            if (s1 > 39) s1 = 39;
        end
        tb  = wide && (va[55] ? ctrl[38] : ctrl[37]);
        top = tb ? w - 8 : w;
        m0 = (s0 != 0);
        for (int i = w - s0; i < top; i++) if (va[i]) m0 = 0;
        m1 = (s1 != 0);
        for (int i = w - s1; i < top; i++) if (!va[i]) m1 = 0;
        f = 0; s = 0; lv = 0; bs = '0;
        if (m0)           s = 0;
        else if (m1)      s = 1;
        else if (s0 == 0) s = 0;
        else if (s1 == 0) s = 1;
        else              f = 1;
        if (!f) begin
            ew  = w - (s ? s1 : s0);
            lv  = (ew >= 40) ? 0 : (ew >= 31) ? 1 : (ew >= 22) ? 2 : 3;
            sh  = ew - 9 * (4 - lv);
            raw = s ? b1[47:0] : b0[47:0];
            bs  = (raw >> sh) << sh;
        end
    endtask

    task automatic run_one(input string req, input bit wide, input logic [63:0] va,
                           input logic [63:0] ctrl, input logic [63:0] b0, input logic [63:0] b1);
        bit f, s;
        int lv;
        logic [47:0] bs;
        req_valid = 1'b1;
        req_wide  = wide;
        req_vaddr = va;
        req_ctrl  = ctrl;
        req_base0 = b0;
        req_base1 = b1;
        ref_model(wide, va, ctrl, b0, b1, f, s, lv, bs);
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " R1 valid"}, 64'(rsp_valid), 64'(1));
        chk({req, " fault"},    64'(rsp_fault), 64'(f));
        chk({req, " sel"},      64'(rsp_sel),   64'(s));
        chk({req, " level"},    64'(rsp_level), 64'(lv));
        chk({req, " base"},     64'(rsp_base),  64'(bs));
    endtask

    logic [63:0] ones = '1;
    logic [63:0] pat  = 64'h0123_4567_89AB_CDEF;

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset valid", 64'(rsp_valid), 64'(0));
        chk("R1 reset base",  64'(rsp_base),  64'(0));
        chk("R1 reset fault", 64'(rsp_fault), 64'(0));

        // Low and high region, 48-bit range at level 0
        run_one("R3 low 48b", 1, 64'h0000_1234_5678_9000, mk_ctrl(16, 16, 0, 0), ones, pat);
        run_one("R4 high 48b", 1, 64'hFFFF_8000_0000_0000, mk_ctrl(16, 16, 0, 0), pat, ones);
        run_one("R5 gap fault", 1, 64'h0001_0000_0000_0000, mk_ctrl(16, 16, 0, 0), ones, ones);
        // Clamping
        run_one("R2 clamp zero", 1, 64'h0000_0000_0000_1000, mk_ctrl(0, 0, 0, 0), ones, ones);
        run_one("R2 R8 clamp max", 1, 64'h0000_0000_0100_0000, mk_ctrl(63, 63, 0, 0), ones, ones);
        run_one("R8 level1 e39", 1, 64'h0000_0040_0000_0000, mk_ctrl(25, 25, 0, 0), ones, ones);
        run_one("R8 level2 e30", 1, 64'hFFFF_FFFF_E000_0000, mk_ctrl(34, 34, 0, 0), ones, ones);
        // Tag handling
        run_one("R7 tag lo on", 1, 64'hAB00_0000_0000_1000, mk_ctrl(16, 16, 1, 0), ones, ones);
        run_one("R7 tag lo off", 1, 64'hAB00_0000_0000_1000, mk_ctrl(16, 16, 0, 1), ones, ones);
        run_one("R7 tag hi on", 1, 64'h12FF_FF00_0000_0000, mk_ctrl(16, 16, 0, 1), ones, ones);
        run_one("R7 tag hi wrong bit", 1, 64'h12FF_FF00_0000_0000, mk_ctrl(16, 16, 1, 0), ones, ones);
        // 32-bit regime
        run_one("R6 narrow high", 0, 64'hDEAD_BEEF_C000_0000, mk_ctrl(0, 2, 1, 1), ones, ones);
        run_one("R6 narrow low fallback", 0, 64'hFFFF_FFFF_4000_0000, mk_ctrl(0, 2, 1, 1), ones, ones);
        run_one("R6 narrow fault", 0, 64'h0000_0000_4000_0000, mk_ctrl(2, 2, 0, 0), ones, ones);
        run_one("R6 narrow field bits", 0, 64'h0000_0000_0000_0000, mk_ctrl(56, 56, 0, 0), ones, ones);
        run_one("R6 R9 narrow high fallback", 0, 64'h0000_0000_8000_0000, mk_ctrl(1, 0, 0, 0), pat, ones);

        // Idle cycle: no strobe and fields hold
        begin
            logic [47:0] held;
            held = rsp_base;
            req_vaddr = 64'hFFFF_0000_0000_0000;
            req_base0 = '0;
            req_base1 = '0;
            @(negedge clk);
            chk("R1 idle valid", 64'(rsp_valid), 64'(0));
            chk("R1 idle hold",  64'(rsp_base),  64'(held));
        end

        for (int n = 0; n < 400; n++) begin
            bit          wide;
            int          k;
            logic [63:0] va, ctrl;
            wide = ($urandom_range(0, 3) != 0);
            ctrl = {$urandom, $urandom};
            k    = $urandom_range(0, 63);
            case ($urandom_range(0, 3))
                0: va = {$urandom, $urandom} >> k;
                1: va = ~({$urandom, $urandom} >> k);
                default: va = {$urandom, $urandom};
            endcase
            if ($urandom_range(0, 3) == 0) va[63:56] = 8'($urandom);
            if (!wide && $urandom_range(0, 1) == 1) va[31:0] = 32'(va[63:32]);
            run_one("R3 R4 R9 random", wide, va, ctrl, {$urandom, $urandom}, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule